// File: doc/BRIEF.md
# DMA Channel Allocation Arbiter

A chip with many DMA requesters and only a handful of physical transfer engines needs a referee. This block keeps a small pool of physical channels, usually 4 to 8, and decides which logical requester drives each one. A requester that asks for service gets the lowest-numbered channel that is free and that it may use. If no such channel exists, the requester is parked in a waiting state. When a channel finishes, it goes straight to a parked requester that can use it, so it never passes through a free state in between.

Each requester has a routing word. The word holds one 4-bit field per channel. The field says whether the channel is usable by that requester and which hardware request line the channel should listen to. Memory-copy requesters ignore these restrictions. So does every requester while a global select-mode input is high. Commands reach the block one per cycle. All outputs are registered.

Top module: `chan_alloc_arb`

## Requirements
- R1: After reset every requester is IDLE, no channel is busy, and `grant_valid` and `err` are low. The state codes on `req_state` are IDLE=0, RUNNING=1 and WAITING=2, with code 3 never used.
- R2: The routing field for requester r and channel c sits at `route_map[(r*NUM_CH+c)*4 +: 4]`. Bit 3 marks the channel as usable and bits 2:0 give the request source. A requester with `is_copy` set, or any requester while `sel_mode` is high, may use every channel regardless of bit 3.
- R3: A request (op 0) from an IDLE requester takes the lowest-indexed channel that is not busy and is permitted. In the next cycle the channel is busy and owned by that requester, the requester is RUNNING, and `grant_valid` pulses for one cycle. The pulse carries the requester, the channel and bits 2:0 of that channel's routing field. The number of RUNNING requesters always equals the number of busy channels.
- R4: A request from an IDLE requester when no permitted channel is free moves it to WAITING, and no grant is issued.
- R5: A request from a WAITING or RUNNING requester has no effect: no grant is issued, and neither state nor channel occupancy changes.
- R6: A release (op 1) from a RUNNING requester returns it to IDLE. Its channel goes first to the lowest-indexed WAITING memory-copy requester, even when a lower-indexed peripheral requester is also waiting. The new owner becomes RUNNING and a grant pulse is issued for it.
- R7: If no memory-copy requester is waiting, the released channel goes to the lowest-indexed WAITING peripheral requester that is permitted on that channel. Waiters not permitted on it stay WAITING.
- R8: If no waiter qualifies, the released channel becomes not busy and no grant is issued.
- R9: A terminate (op 2) from a RUNNING requester behaves exactly like a release. A terminate from a WAITING requester returns it to IDLE without any error.
- R10: A release or terminate from an IDLE requester, or a release from a WAITING requester, changes nothing and pulses `err` high for exactly one cycle.
- R11: Op 3 is reserved and has no effect. At most one command is accepted per cycle, qualified by `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 request, 1 release, 2 terminate, 3 reserved |
| cmd_id | input | IDW | Requester issuing the command |
| is_copy | input | NUM_REQ | Per requester: memory-copy class |
| sel_mode | input | 1 | Every requester may use every channel |
| route_map | input | NUM_REQ*NUM_CH*4 | Routing fields, one nibble per requester and channel |
| grant_valid | output | 1 | One-cycle pulse: a channel was handed out |
| grant_id | output | IDW | Requester receiving the channel |
| grant_ch | output | CHW | Channel index granted |
| grant_src | output | 3 | Request source from the routing field |
| ch_busy | output | NUM_CH | Channel has an owner |
| ch_owner | output | NUM_CH*IDW | Owner of each channel |
| req_state | output | NUM_REQ*2 | State of each requester |
| err | output | 1 | One-cycle pulse: release or terminate from a non-owner |

## Verification
The bench targets the following corner cases:
- **Skipping a busy permitted channel.** A requester whose first permitted channel is busy must take a higher one. A scan that stops at the first permitted channel would hand out a channel that is already owned.
- **Class order on handover.** A memory-copy waiter must beat a lower-indexed peripheral waiter. A single flat scan would give the channel to the peripheral.
- **Permission filter on handover.** Peripheral waiters that may not use the released channel must be passed over. A design that skipped this check would bind a requester to a channel it is not allowed to use.
- **Commands that must change nothing.** Repeated requests, stray releases, terminates of parked requesters and the reserved op are all exercised. A wrong design would emit grants the scoreboard does not expect, leak channels, or raise `err` when it should stay low.
- **Select mode.** The bench checks that the lowest free channel is taken even when the routing word does not permit it.

// File: rtl/chan_alloc_arb.sv
module chan_alloc_arb #(
  parameter int NUM_REQ = 8,
  parameter int NUM_CH  = 4,
  localparam int IDW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [1:0]                  cmd_op,
  input  logic [IDW-1:0]              cmd_id,
  input  logic [NUM_REQ-1:0]          is_copy,
  input  logic                        sel_mode,
  input  logic [NUM_REQ*NUM_CH*4-1:0] route_map,
  output logic                        grant_valid,
  output logic [IDW-1:0]              grant_id,
  output logic [CHW-1:0]              grant_ch,
  output logic [2:0]                  grant_src,
  output logic [NUM_CH-1:0]           ch_busy,
  output logic [NUM_CH*IDW-1:0]       ch_owner,
  output logic [NUM_REQ*2-1:0]        req_state,
  output logic                        err
);
  localparam logic [1:0] S_IDLE = 2'd0, S_RUN = 2'd1, S_WAIT = 2'd2;
  localparam logic [1:0] OP_REQ = 2'd0, OP_REL = 2'd1, OP_KILL = 2'd2;

  logic [1:0]        st    [NUM_REQ];
  logic [IDW-1:0]    owner [NUM_CH];
  logic [NUM_CH-1:0] perm  [NUM_REQ];

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign perm[r][c] = is_copy[r] | sel_mode | route_map[(r*NUM_CH+c)*4+3];
    end
    assign req_state[r*2 +: 2] = st[r];
  end
  for (genvar c = 0; c < NUM_CH; c++) begin : g_own
    assign ch_owner[c*IDW +: IDW] = owner[c];
  end

  logic           free_hit, copy_hit, per_hit;
  logic [CHW-1:0] free_ch, own_ch;
  logic [IDW-1:0] copy_id, per_id;
  logic [1:0]     cur_st;

  assign cur_st = st[cmd_id];

  always_comb begin
    free_hit = 1'b0;
    free_ch  = '0;
    own_ch   = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (!ch_busy[c] && perm[cmd_id][c]) begin
        free_hit = 1'b1;
        free_ch  = CHW'(c);
      end
      if (ch_busy[c] && owner[c] == cmd_id) own_ch = CHW'(c);
    end
  end

  always_comb begin
    copy_hit = 1'b0;
    copy_id  = '0;
    per_hit  = 1'b0;
    per_id   = '0;
    for (int r = NUM_REQ - 1; r >= 0; r--) begin
      if (st[r] == S_WAIT && is_copy[r]) begin
        copy_hit = 1'b1;
        copy_id  = IDW'(r);
      end
      if (st[r] == S_WAIT && !is_copy[r] && perm[r][own_ch]) begin
        per_hit = 1'b1;
        per_id  = IDW'(r);
      end
    end
  end

  function automatic logic [2:0] src_of(input logic [IDW-1:0] id, input logic [CHW-1:0] ch);
    return route_map[(int'(id)*NUM_CH + int'(ch))*4 +: 3];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REQ; r++) st[r] <= S_IDLE;
      for (int c = 0; c < NUM_CH; c++) owner[c] <= '0;
      ch_busy     <= '0;
      grant_valid <= 1'b0;
      grant_id    <= '0;
      grant_ch    <= '0;
      grant_src   <= '0;
      err         <= 1'b0;
    end else begin
      grant_valid <= 1'b0;
      err         <= 1'b0;
      if (cmd_valid) begin
        if (cmd_op == OP_REQ) begin
          if (cur_st == S_IDLE) begin
            if (free_hit) begin
              ch_busy[free_ch] <= 1'b1;
              owner[free_ch]   <= cmd_id;
              st[cmd_id]       <= S_RUN;
              grant_valid      <= 1'b1;
              grant_id         <= cmd_id;
              grant_ch         <= free_ch;
              grant_src        <= src_of(cmd_id, free_ch);
            end else begin
              st[cmd_id] <= S_WAIT;
            end
          end
        end else if (cmd_op == OP_REL || cmd_op == OP_KILL) begin
          if (cur_st == S_RUN) begin
            st[cmd_id] <= S_IDLE;
            if (copy_hit || per_hit) begin
              owner[own_ch] <= copy_hit ? copy_id : per_id;
              st[copy_hit ? copy_id : per_id] <= S_RUN;
              grant_valid   <= 1'b1;
              grant_id      <= copy_hit ? copy_id : per_id;
              grant_ch      <= own_ch;
              grant_src     <= src_of(copy_hit ? copy_id : per_id, own_ch);
            end else begin
              ch_busy[own_ch] <= 1'b0;
            end
          end else if (cmd_op == OP_KILL && cur_st == S_WAIT) begin
            st[cmd_id] <= S_IDLE;
          end else begin
            err <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/chan_alloc_arb_chk.sv
module chan_alloc_arb_chk #(
  parameter int NUM_REQ = 8,
  parameter int NUM_CH  = 4,
  localparam int IDW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic [1:0]            cmd_op,
  input logic [IDW-1:0]        cmd_id,
  input logic                  grant_valid,
  input logic [IDW-1:0]        grant_id,
  input logic [CHW-1:0]        grant_ch,
  input logic [NUM_CH-1:0]     ch_busy,
  input logic [NUM_CH*IDW-1:0] ch_owner,
  input logic [NUM_REQ*2-1:0]  req_state,
  input logic                  err
);
  logic [NUM_REQ-1:0] run_vec;
  for (genvar r = 0; r < NUM_REQ; r++) begin : g_r
    assign run_vec[r] = (req_state[r*2 +: 2] == 2'd1);
    p_state_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_state[r*2 +: 2] != 2'd3);
  end

  p_grant_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ch_busy[grant_ch] && ch_owner[grant_ch*IDW +: IDW] == grant_id
                    && req_state[grant_id*2 +: 2] == 2'd1);

  p_run_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(run_vec) == $countones(ch_busy));

  p_wait_req_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd0 && req_state[cmd_id*2 +: 2] == 2'd2
    |=> req_state[$past(cmd_id)*2 +: 2] == 2'd2 && !grant_valid);

  p_stray_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd1 && req_state[cmd_id*2 +: 2] != 2'd1
    |=> err && !grant_valid && $stable(ch_busy) && $stable(req_state));

  p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err || $past(cmd_valid));
endmodule

bind chan_alloc_arb chan_alloc_arb_chk #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
  .grant_valid(grant_valid), .grant_id(grant_id), .grant_ch(grant_ch),
  .ch_busy(ch_busy), .ch_owner(ch_owner), .req_state(req_state), .err(err)
);

// File: tb/chan_alloc_arb_bench.sv
`timescale 1ns/1ps
module chan_alloc_arb_bench;
  localparam int NR = 8, NC = 4, IDW = 3, CHW = 2;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [IDW-1:0] cmd_id = 0;
  logic [NR-1:0] is_copy = 8'b1100_0000;
  logic sel_mode = 0;
  logic [NR*NC*4-1:0] route_map = '0;
  logic grant_valid, err;
  logic [IDW-1:0] grant_id;
  logic [CHW-1:0] grant_ch;
  logic [2:0] grant_src;
  logic [NC-1:0] ch_busy;
  logic [NC*IDW-1:0] ch_owner;
  logic [NR*2-1:0] req_state;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  chan_alloc_arb #(.NUM_REQ(NR), .NUM_CH(NC)) u_chan_alloc_arb (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
    .is_copy(is_copy), .sel_mode(sel_mode), .route_map(route_map),
    .grant_valid(grant_valid), .grant_id(grant_id), .grant_ch(grant_ch),
    .grant_src(grant_src), .ch_busy(ch_busy), .ch_owner(ch_owner),
    .req_state(req_state), .err(err));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_grant(input string tag, input int id, input int ch, input int src);
    exp_q.push_back({3'(id), 2'(ch), 3'(src)});
    tag_q.push_back(tag);
  endtask

  task automatic cmd(input logic [1:0] op, input int id);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_id = IDW'(id);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  function automatic logic [1:0] st(input int r);
    return req_state[r*2 +: 2];
  endfunction

  function automatic logic [IDW-1:0] own(input int c);
    return ch_owner[c*IDW +: IDW];
  endfunction

  task automatic set_route(input int id, input int ch, input int src);
    route_map[(id*NC+ch)*4 +: 4] = {1'b1, 3'(src)};
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && grant_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5 unexpected grant: actual %0h expected none", {grant_id, grant_ch, grant_src});
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({grant_id, grant_ch, grant_src} !== e) begin
          n_bad++;
          $display("FAIL %s grant: actual %0h expected %0h", t, {grant_id, grant_ch, grant_src}, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    set_route(0, 0, 5); set_route(0, 2, 1);
    set_route(1, 1, 3);
    set_route(2, 2, 4);
    set_route(3, 0, 2); set_route(3, 3, 6);
    set_route(4, 1, 7); set_route(4, 3, 0);
    set_route(5, 3, 2);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 states", req_state, 0);
    chk("R1 busy", ch_busy, 0);
    chk("R1 grant", grant_valid, 0);
    chk("R1 err", err, 0);

    expect_grant("R3", 0, 0, 5); cmd(0, 0);
    chk("R3 state0", st(0), 1); chk("R3 busy", ch_busy, 4'b0001);
    expect_grant("R3", 1, 1, 3); cmd(0, 1);
    expect_grant("R3", 2, 2, 4); cmd(0, 2);
    expect_grant("R3 skip busy", 3, 3, 6); cmd(0, 3);
    chk("R3 busy full", ch_busy, 4'b1111);

    cmd(0, 6); chk("R4 copy waits", st(6), 2);
    cmd(0, 4); cmd(0, 5);
    chk("R4 state5", st(5), 2);

    cmd(0, 6); chk("R5 wait ignored", st(6), 2);
    cmd(0, 0); chk("R5 run ignored", st(0), 1);
    chk("R5 busy", ch_busy, 4'b1111);

    expect_grant("R6", 6, 1, 0); cmd(1, 1);
    chk("R6 releaser idle", st(1), 0);
    chk("R6 copy running", st(6), 1);
    chk("R6 owner ch1", own(1), 6);
    chk("R6 peripheral still waits", st(4), 2);

    cmd(1, 2);
    chk("R8 busy", ch_busy, 4'b1011);
    chk("R8 releaser idle", st(2), 0);
    chk("R7 non-permitted stays", st(5), 2);

    expect_grant("R7", 4, 3, 0); cmd(1, 3);
    chk("R7 state4", st(4), 1);
    chk("R7 state5", st(5), 2);
    chk("R7 owner ch3", own(3), 4);

    cmd(1, 1);
    chk("R10 err", err, 1);
    chk("R10 busy", ch_busy, 4'b1011);
    chk("R10 state1", st(1), 0);
    @(negedge clk);
    chk("R10 err one cycle", err, 0);

    cmd(2, 5);
    chk("R9 kill wait", st(5), 0);
    chk("R9 no err", err, 0);
    cmd(2, 4);
    chk("R9 kill run state", st(4), 0);
    chk("R9 kill run busy", ch_busy, 4'b0011);

    sel_mode = 1;
    expect_grant("R2 select mode", 5, 2, 0); cmd(0, 5);
    sel_mode = 0;
    chk("R2 state5", st(5), 1);
    expect_grant("R2 copy any", 7, 3, 0); cmd(0, 7);
    chk("R2 busy", ch_busy, 4'b1111);

    cmd(2, 1);
    chk("R10 kill idle err", err, 1);

    cmd(3, 0);
    chk("R11 reserved state", st(0), 1);
    chk("R11 reserved err", err, 0);
    chk("R11 reserved busy", ch_busy, 4'b1111);

    repeat (2) @(negedge clk);
    chk("R3 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule